// File: doc/BRIEF.md
# Trigger Busy Generator

This block produces the single BUSY line that tells the trigger system to hold off new triggers. BUSY is raised whenever any of four causes is present: the timing receiver reports that it is not ready, the multi-event buffer has filled up to a host-set limit, a hold-off window that follows each L0 trigger is still running, or the trigger receiver is part way through taking in a sequence. Each cause is reported on its own bit of a 16-bit status word, next to the current buffer occupancy and the programmed limit, so the host can see why the system is busy.

The block keeps the buffer occupancy count itself. An accepted event adds one and an event-complete pulse removes one. The hold-off length is programmed in 10 us steps. A prescaler derives each step from the 25 ns system clock, which gives 400 cycles per step by default. A running counter adds up every cycle in which BUSY is high, and the host reads it as an upper half and a lower half.

Top module: `trig_busy_gen`

## Requirements
- R1: `busy_o` is 1 in a cycle exactly when at least one cause holds: `ttc_ready_i` is low, the buffer is full, the hold-off is active, or `rx_busy_i` is high. `busy_o` follows `ttc_ready_i` and `rx_busy_i` in the same cycle.
- R2: `status_o` uses a fixed bit layout. Bit 15 is ready-low, bit 14 is buffer-full, bit 13 is hold-off-active and bit 12 is receiver-busy. Bits 11:8 always read 0, bits 7:4 hold the current occupancy count and bits 3:0 hold the buffer limit.
- R3: The buffer is full when the count is greater than or equal to the limit. The 4-bit limit resets to 8. A cycle with `cfg_limit_wr_i` high loads `cfg_limit_i`, and the new value shows from the next cycle.
- R4: The occupancy count resets to 0. An `evt_accept_i` pulse alone adds 1 and an `evt_done_i` pulse alone subtracts 1, each visible from the next cycle. When both arrive in the same cycle the count does not change. The count stops at 15 going up and at 0 going down.
- R5: An `l0_i` pulse starts the hold-off. It is active from the next cycle for exactly hold_len x STEP_CYCLES cycles (STEP_CYCLES defaults to 400). A hold length of 0 starts no hold-off.
- R6: An `l0_i` pulse that arrives while a hold-off is running restarts the window for its full length.
- R7: The 16-bit hold length resets to 10 (0x000A). A cycle with `cfg_hold_wr_i` high loads `cfg_hold_i`, and the next L0 pulse uses the new value.
- R8: When the hold-off expires while the buffer is still full, `busy_o` stays high.
- R9: The busy-time counter resets to 0 and adds 1 on every clock edge at which `busy_o` is high. Its upper and lower halves appear on `busy_time_hi_o` and `busy_time_lo_o`.
- R10: The busy-time counter stops at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ttc_ready_i | input | 1 | Timing receiver ready |
| rx_busy_i | input | 1 | Trigger receiver is taking in a sequence |
| l0_i | input | 1 | L0 trigger pulse |
| evt_accept_i | input | 1 | Event accepted into the buffer |
| evt_done_i | input | 1 | Event complete, buffer freed |
| cfg_limit_wr_i | input | 1 | Load the buffer limit |
| cfg_limit_i | input | 4 | New buffer limit |
| cfg_hold_wr_i | input | 1 | Load the hold length |
| cfg_hold_i | input | 16 | New hold length in steps |
| busy_o | output | 1 | BUSY to the trigger system |
| status_o | output | 16 | Cause and occupancy status word |
| busy_time_hi_o | output | TIME_W/2 | Upper half of the busy-time count |
| busy_time_lo_o | output | TIME_W/2 | Lower half of the busy-time count |

## Verification
Two pairs of events can fall in the same cycle and need checking. An accept and a complete pulse can arrive together, and the bench drives them side by side at an empty count, a mid count and a full count, expecting the count to stay where it is. The hold-off can also end while the buffer is still full. The bench sets the limit to 0 and fires an L0 with a one-step hold. Once the hold-off bit drops it expects BUSY to stay high with only the full bit set. A second L0 sent in the middle of a running window must stretch the window by a full length from that second pulse.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;

    localparam int OCC_W  = 4;
    localparam int LIM_W  = 4;
    localparam int STAT_W = 16;

    localparam int ST_NOTRDY = 15;
    localparam int ST_FULL   = 14;
    localparam int ST_HOLD   = 13;
    localparam int ST_RXBUSY = 12;

    localparam logic [LIM_W-1:0] LIMIT_RST = LIM_W'(8);

    typedef struct packed {
        logic not_ready;
        logic full;
        logic hold;
        logic rx_busy;
    } busy_cause_t;

    function automatic logic any_cause(input busy_cause_t c);
        return c.not_ready | c.full | c.hold | c.rx_busy;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input busy_cause_t c,
                                                      input logic [OCC_W-1:0] cnt,
                                                      input logic [LIM_W-1:0] lim);
        return {c, 4'b0000, cnt, lim};
    endfunction

endpackage

// File: rtl/busy_occupancy.sv
module busy_occupancy
    import trig_busy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             done_i,
    output logic [OCC_W-1:0] count_o
);
    localparam logic [OCC_W-1:0] CNT_MAX = '1;

    logic [OCC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case ({accept_i, done_i})
                2'b10: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01: if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/busy_holdoff.sv
module busy_holdoff #(
    parameter int STEP_CYCLES = 400,
    parameter int HOLD_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l0_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              active_o
);
    localparam int PS_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(STEP_CYCLES - 1);

    logic [PS_W-1:0]   ps_q;
    logic [HOLD_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q  <= '0;
            rem_q <= '0;
        end else if (l0_i) begin
            ps_q  <= '0;
            rem_q <= hold_len_i;
        end else if (rem_q != '0) begin
            if (ps_q == PS_LAST) begin
                ps_q  <= '0;
                rem_q <= rem_q - 1'b1;
            end else begin
                ps_q  <= ps_q + 1'b1;
            end
        end
    end

    assign active_o = (rem_q != '0);
endmodule

// File: rtl/busy_accum.sv
module busy_accum #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    output logic [TIME_W-1:0] total_o
);
    localparam logic [TIME_W-1:0] T_MAX = '1;

    logic [TIME_W-1:0] tot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q <= '0;
        end else if (busy_i && tot_q != T_MAX) begin
            tot_q <= tot_q + 1'b1;
        end
    end

    assign total_o = tot_q;
endmodule

// File: rtl/trig_busy_gen.sv
module trig_busy_gen
    import trig_busy_pkg::*;
#(
    parameter int STEP_CYCLES = 400,
    parameter int HOLD_W      = 16,
    parameter int TIME_W      = 32,
    parameter logic [HOLD_W-1:0] HOLD_RST = HOLD_W'(10)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ttc_ready_i,
    input  logic                  rx_busy_i,
    input  logic                  l0_i,
    input  logic                  evt_accept_i,
    input  logic                  evt_done_i,
    input  logic                  cfg_limit_wr_i,
    input  logic [LIM_W-1:0]      cfg_limit_i,
    input  logic                  cfg_hold_wr_i,
    input  logic [HOLD_W-1:0]     cfg_hold_i,
    output logic                  busy_o,
    output logic [STAT_W-1:0]     status_o,
    output logic [TIME_W/2-1:0]   busy_time_hi_o,
    output logic [TIME_W/2-1:0]   busy_time_lo_o
);
    localparam int HALF_W = TIME_W / 2;

    logic [LIM_W-1:0]  limit_q;
    logic [HOLD_W-1:0] hold_len_q;
    logic [OCC_W-1:0]  occ;
    logic              hold_act;
    logic [TIME_W-1:0] busy_total;
    busy_cause_t       cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q    <= LIMIT_RST;
            hold_len_q <= HOLD_RST;
        end else begin
            if (cfg_limit_wr_i) limit_q    <= cfg_limit_i;
            if (cfg_hold_wr_i)  hold_len_q <= cfg_hold_i;
        end
    end

    busy_occupancy u_occ (
        .clk      (clk),
        .rst      (rst),
        .accept_i (evt_accept_i),
        .done_i   (evt_done_i),
        .count_o  (occ)
    );

    busy_holdoff #(
        .STEP_CYCLES (STEP_CYCLES),
        .HOLD_W      (HOLD_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .l0_i       (l0_i),
        .hold_len_i (hold_len_q),
        .active_o   (hold_act)
    );

    always_comb begin
        cause.not_ready = ~ttc_ready_i;
        cause.full      = (occ >= limit_q);
        cause.hold      = hold_act;
        cause.rx_busy   = rx_busy_i;
    end

    assign busy_o   = any_cause(cause);
    assign status_o = pack_status(cause, occ, limit_q);

    busy_accum #(.TIME_W(TIME_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy_o),
        .total_o (busy_total)
    );

    assign busy_time_hi_o = busy_total[TIME_W-1:HALF_W];
    assign busy_time_lo_o = busy_total[HALF_W-1:0];
endmodule

// File: rtl/trig_busy_chk.sv
module trig_busy_chk #(
    parameter int HOLD_W = 16,
    parameter int TIME_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                l0_i,
    input logic                busy_o,
    input logic [15:0]         status_o,
    input logic [HOLD_W-1:0]   hold_len,
    input logic [TIME_W/2-1:0] t_hi,
    input logic [TIME_W/2-1:0] t_lo
);
    logic              seen;
    logic [TIME_W-1:0] t_all;
    assign t_all = {t_hi, t_lo};

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_BUSY_OR: assert property (@(posedge clk) disable iff (rst)
        busy_o == (|status_o[15:12]));  // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status_o[11:8] == 4'b0000);  // R2

    AST_FULL_CMP: assert property (@(posedge clk) disable iff (rst)
        status_o[14] == (status_o[7:4] >= status_o[3:0]));  // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        seen |-> ((status_o[7:4] == $past(status_o[7:4])) ||
                  (status_o[7:4] == $past(status_o[7:4]) + 4'd1) ||
                  (status_o[7:4] == $past(status_o[7:4]) - 4'd1)));  // R4

    AST_HOLD_START: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(l0_i) && $past(hold_len) != '0) |-> status_o[13]);  // R5

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(busy_o) && $past(t_all) != '1) |-> t_all == $past(t_all) + 1'b1);  // R9

    AST_TIME_SAT: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(t_all) == '1) |-> t_all == '1);  // R10
endmodule

bind trig_busy_gen trig_busy_chk #(.HOLD_W(HOLD_W), .TIME_W(TIME_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .l0_i     (l0_i),
    .busy_o   (busy_o),
    .status_o (status_o),
    .hold_len (hold_len_q),
    .t_hi     (busy_time_hi_o),
    .t_lo     (busy_time_lo_o)
);

// File: tb/tb_trig_busy_gen.sv
`timescale 1ns/100ps
module tb_trig_busy_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ready = 1'b1, rxb = 1'b0, l0 = 1'b0, acc = 1'b0, done = 1'b0;
    logic lim_wr = 1'b0, hold_wr = 1'b0;
    logic [3:0]  lim_v = '0;
    logic [15:0] hold_v = '0;
    logic        busy, busy_s;
    logic [15:0] stat, stat_s;
    logic [15:0] thi, tlo;
    logic [3:0]  shi, slo;

    int n_chk = 0, n_fail = 0;
    int model_cnt;

    always #2.5 clk = ~clk;

    trig_busy_gen dut (
        .clk(clk), .rst(rst), .ttc_ready_i(ready), .rx_busy_i(rxb), .l0_i(l0),
        .evt_accept_i(acc), .evt_done_i(done), .cfg_limit_wr_i(lim_wr), .cfg_limit_i(lim_v),
        .cfg_hold_wr_i(hold_wr), .cfg_hold_i(hold_v), .busy_o(busy), .status_o(stat),
        .busy_time_hi_o(thi), .busy_time_lo_o(tlo));

    trig_busy_gen #(.TIME_W(8)) dut_sat (
        .clk(clk), .rst(rst), .ttc_ready_i(ready), .rx_busy_i(rxb), .l0_i(l0),
        .evt_accept_i(acc), .evt_done_i(done), .cfg_limit_wr_i(lim_wr), .cfg_limit_i(lim_v),
        .cfg_hold_wr_i(hold_wr), .cfg_hold_i(hold_v), .busy_o(busy_s), .status_o(stat_s),
        .busy_time_hi_o(shi), .busy_time_lo_o(slo));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        model_cnt = 0;
    endtask

    task automatic set_limit(input logic [3:0] v);
        lim_v = v; lim_wr = 1'b1; tick(); lim_wr = 1'b0;
    endtask

    task automatic set_hold(input logic [15:0] v);
        hold_v = v; hold_wr = 1'b1; tick(); hold_wr = 1'b0;
    endtask

    task automatic fire_l0();
        l0 = 1'b1; tick(); l0 = 1'b0; settle();
    endtask

    task automatic measure_hold(output int n);
        n = 0;
        while (stat[13] && n < 6000) begin
            n++; tick(); settle();
        end
    endtask

    task automatic pulse(input logic a, input logic d);
        acc = a; done = d; tick(); acc = 1'b0; done = 1'b0; settle();
        if (a && !d && model_cnt < 15) model_cnt++;
        if (d && !a && model_cnt > 0)  model_cnt--;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        settle();
        // Reset state: R2 layout, R3 limit 8, R9 time 0
        chk(stat == 16'h0008, "R2 reset status", stat, 16'h0008);
        chk(busy == 1'b0, "R1 idle busy", busy, 0);
        chk({thi, tlo} == 0, "R9 reset busy time", {thi, tlo}, 0);

        // R1/R2: ready and receiver-busy causes, all four combinations
        for (int k = 0; k < 4; k++) begin
            ready = k[0]; rxb = k[1]; settle();
            chk(busy == (!k[0] || k[1]), "R1 ready/rx cause", busy, (!k[0] || k[1]));
            chk(stat[15] == !k[0] && stat[12] == k[1], "R2 cause bits", stat[15:12],
                {!k[0], 2'b00, k[1]});
            tick();
        end
        ready = 1'b1; rxb = 1'b0;

        // R3/R4: sweep all limits against all counts
        for (int lim = 0; lim < 16; lim++) begin
            set_limit(lim[3:0]); settle();
            chk(stat[3:0] == lim[3:0], "R3 limit field", stat[3:0], lim);
            for (int s = 0; s < 17; s++) begin
                chk(stat[7:4] == model_cnt[3:0], "R4 count up", stat[7:4], model_cnt);
                chk(stat[14] == (model_cnt >= lim) && busy == (model_cnt >= lim),
                    "R3 full compare", {stat[14], busy}, {2{model_cnt >= lim}});
                pulse(1'b1, 1'b0);
            end
            chk(stat[7:4] == 4'd15, "R4 saturate high", stat[7:4], 15);
            for (int s = 0; s < 17; s++) begin
                chk(stat[7:4] == model_cnt[3:0], "R4 count down", stat[7:4], model_cnt);
                chk(stat[14] == (model_cnt >= lim), "R3 full compare down", stat[14], (model_cnt >= lim));
                pulse(1'b0, 1'b1);
            end
            chk(stat[7:4] == 4'd0, "R4 saturate low", stat[7:4], 0);
        end

        // R4: simultaneous accept and done at 0, 5 and 15
        pulse(1'b1, 1'b1);
        chk(stat[7:4] == 4'd0, "R4 both at 0", stat[7:4], 0);
        for (int s = 0; s < 5; s++) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        chk(stat[7:4] == 4'd5, "R4 both at 5", stat[7:4], 5);
        for (int s = 0; s < 12; s++) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        chk(stat[7:4] == 4'd15, "R4 both at 15", stat[7:4], 15);

        // R5/R7: default hold length 10 after reset
        do_reset(); settle();
        chk(stat[13] == 1'b0, "R5 idle hold", stat[13], 0);
        fire_l0();
        measure_hold(n);
        chk(n == 4000, "R7 default hold length", n, 4000);
        chk(busy == 1'b0, "R5 busy after hold", busy, 0);

        // R5: hold length 3
        set_hold(16'd3);
        fire_l0();
        chk(busy == 1'b1, "R5 busy during hold", busy, 1);
        measure_hold(n);
        chk(n == 1200, "R5 hold duration", n, 1200);

        // R6: restart mid-window
        fire_l0();
        repeat (500) tick();
        settle();
        chk(stat[13] == 1'b1, "R6 active before restart", stat[13], 1);
        fire_l0();
        measure_hold(n);
        chk(n == 1200, "R6 restart full length", n, 1200);

        // R5/R7: zero length gives no hold
        set_hold(16'd0);
        fire_l0();
        chk(stat[13] == 1'b0 && busy == 1'b0, "R5 zero hold", {stat[13], busy}, 0);

        // R8: hold expiring while full keeps busy
        set_hold(16'd1);
        set_limit(4'd0);
        fire_l0();
        measure_hold(n);
        chk(n == 400, "R8 one-step hold", n, 400);
        chk(busy == 1'b1 && stat[15:12] == 4'b0100, "R8 busy stays on full",
            {busy, stat[15:12]}, 5'b1_0100);
        set_limit(4'd8);

        // R9/R10: busy-time accumulation and saturation
        do_reset();
        ready = 1'b0;
        repeat (20) tick();
        settle();
        chk({thi, tlo} == 32'd20, "R9 busy time count", {thi, tlo}, 20);
        chk({shi, slo} == 8'd20, "R9 halves on small counter", {shi, slo}, 20);
        ready = 1'b1;
        repeat (5) tick();
        settle();
        chk({thi, tlo} == 32'd20, "R9 no count while idle", {thi, tlo}, 20);
        ready = 1'b0;
        repeat (300) tick();
        settle();
        chk({thi, tlo} == 32'd320, "R9 busy time long", {thi, tlo}, 320);
        chk({shi, slo} == 8'hFF, "R10 saturation", {shi, slo}, 8'hFF);
        ready = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule